// File: doc/BRIEF.md
# Serial Configuration Chain Node

This block sits in one device of a chain of configurable devices wired in series. Every device's serial output feeds the next device's serial input, and all of them share one shift clock. The node watches its serial input for an 8-bit sync pattern. It then replays that pattern and the 24-bit length field that follows it to the device downstream. Next it absorbs its own configuration frames while holding its output idle-high. After that it turns into a plain wire that passes every later bit to the rest of the chain.

Input bits are sampled on the rising edge of the shift clock. Output bits change on the falling edge. A downstream device therefore samples each bit half a period after it is launched. Because the output stays high while this node takes its own frames, no device further down the chain ever sees a frame start pair that is not meant for it. The node can be re-armed for a fresh chain load during reconfiguration, but only when the chain-configuration enable bit is set.

Each absorbed frame is presented as a parallel word with a one-cycle valid strobe. A sticky done flag marks the end of the node's own load. The parameters must satisfy `NUM_FRAMES*(DATA_W+2) >= PRE_W` so that the header replay ends before bypass begins.

Top module: `cfgfwd_chain_node`

## Requirements
- R1: After a synchronous active-high reset, `cfg_dout` is 1, `load_done` is 0 and `frame_valid` is 0. The output stays 1 until the input has carried the sync pattern 0xF2, sent most significant bit first, as 8 consecutive bits.
- R2: `cfg_din` is sampled on the rising edge of `clk`. `cfg_dout` changes only on the falling edge, half a period after the rising edge that decides its value.
- R3: After a sync match, the output replays the 8 sync bits and the 24 length bits in order. Each of these 32 header bits appears on the output 8 bit periods after it arrived on the input.
- R4: After the header, `length_count` holds the 24-bit field that followed the sync pattern, received most significant bit first.
- R5: A frame is any number of idle 1 bits, then the start pair 0 then 1, then `DATA_W` data bits, most significant bit first. In the bit period of a frame's last data bit, `frame_word` carries that frame's data and `frame_valid` is high for exactly one cycle.
- R6: From the end of the header replay up to and including the last data bit of the node's last own frame, `cfg_dout` is 1.
- R7: `load_done` rises together with the `frame_valid` of frame number `NUM_FRAMES` and then stays high. From the next input bit onward, each input bit appears on `cfg_dout` in the same bit period.
- R8: Once `load_done` is high, frames passing through the node do not raise `frame_valid`.
- R9: With `chain_cfg_en` low, a pulse on `reconfig_req` is ignored: `load_done` stays high and bypass continues. With `chain_cfg_en` high, a pulse returns the node to sync search: `load_done` goes to 0 and the output goes to 1.
- R10: While the node waits for a start pair, a 0 followed by another 0 keeps it waiting for the 1. So the sequence 0,0,1 also opens a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; input is sampled on the rising edge, output is launched on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| reconfig_req | input | 1 | Request to restart the chain load during reconfiguration |
| chain_cfg_en | input | 1 | Configuration bit that allows `reconfig_req` to take effect |
| cfg_din | input | 1 | Serial bitstream from the upstream device |
| cfg_dout | output | 1 | Serial bitstream to the downstream device |
| frame_word | output | DATA_W | Data of the most recently absorbed own frame |
| frame_valid | output | 1 | One-cycle strobe marking a new `frame_word` |
| length_count | output | LEN_W | Captured length field |
| load_done | output | 1 | Sticky flag: all own frames have been absorbed |

## Verification
The bench builds the node with `DATA_W=8` and `NUM_FRAMES=2`. With these values one stream of a few dozen bits covers the whole sequence: sync search, the delayed header replay, the idle-high hold, the switch to bypass, and a frame that passes through after done. These values also make the header replay overlap the first own frame on the input side, so the output priority between replay and hold is exercised. The stream is built with idle gaps before frames, a 0,0,1 start, and a junk prefix that almost forms the sync pattern. A second load, started through the enabled reconfiguration path, shows that the node re-arms from a state that is already done.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;

  // Input-side progress through one chain load
  typedef enum logic [1:0] {
    PH_SEARCH = 2'd0,
    PH_LEN    = 2'd1,
    PH_FRAMES = 2'd2,
    PH_BYPASS = 2'd3
  } phase_t;

  // Frame parser state while absorbing own frames
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_GOT0 = 2'd1,
    FS_DATA = 2'd2
  } fstate_t;

endpackage

// File: rtl/cfgfwd_seq.sv
module cfgfwd_seq
  import cfgfwd_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   clr,
  input  logic   match,
  input  logic   last_done,
  output phase_t phase
);

  localparam int LCW = (LEN_W > 1) ? $clog2(LEN_W) : 1;

  phase_t         phase_q;
  logic [LCW-1:0] len_cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      phase_q   <= PH_SEARCH;
      len_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_SEARCH: begin
          len_cnt_q <= '0;
          if (match) phase_q <= PH_LEN;
        end
        PH_LEN: begin
          if (len_cnt_q == LCW'(LEN_W - 1)) begin
            phase_q   <= PH_FRAMES;
            len_cnt_q <= '0;
          end else begin
            len_cnt_q <= len_cnt_q + 1'b1;
          end
        end
        PH_FRAMES: begin
          if (last_done) phase_q <= PH_BYPASS;
        end
        default: phase_q <= PH_BYPASS;
      endcase
    end
  end

  assign phase = phase_q;

  // Bypass is left only through a restart
  assert_bypass_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_BYPASS && !clr) |=> (phase_q == PH_BYPASS));

  // The length field lasts exactly LEN_W bits, so frames begin only after it
  assert_frames_after_len_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FRAMES && $past(phase_q) == PH_LEN) |-> ($past(len_cnt_q) == LCW'(LEN_W - 1)));

endmodule

// File: rtl/cfgfwd_hdr_fwd.sv
module cfgfwd_hdr_fwd
  import cfgfwd_pkg::*;
#(
  parameter int             PRE_W   = 8,
  parameter logic [PRE_W-1:0] PATTERN = 8'hF2,
  parameter int             LEN_W   = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             din,
  input  phase_t           phase,
  output logic             match,
  output logic             emit_on,
  output logic             emit_bit,
  output logic [LEN_W-1:0] length_q
);

  localparam int HDR_BITS = PRE_W + LEN_W;
  localparam int ECW      = $clog2(HDR_BITS + 1);

  logic [PRE_W-1:0] hist_q;
  logic [PRE_W-1:0] hist_nxt;
  logic [ECW-1:0]   ecnt_q;
  logic             emit_q;
  logic [LEN_W-1:0] len_q;

  // The history doubles as the replay delay line: PRE_W bit periods
  assign hist_nxt = {hist_q[PRE_W-2:0], din};
  assign match    = (phase == PH_SEARCH) && (hist_nxt == PATTERN);

  always_ff @(posedge clk) begin
    if (clr) begin
      hist_q <= '0;
      ecnt_q <= '0;
      emit_q <= 1'b0;
      len_q  <= '0;
    end else begin
      hist_q <= hist_nxt;
      if (match) begin
        emit_q <= 1'b1;
        ecnt_q <= '0;
      end else if (emit_q) begin
        if (ecnt_q == ECW'(HDR_BITS - 1)) emit_q <= 1'b0;
        ecnt_q <= ecnt_q + 1'b1;
      end
      if (phase == PH_LEN) len_q <= {len_q[LEN_W-2:0], din};
    end
  end

  assign emit_on  = emit_q;
  assign emit_bit = hist_q[PRE_W-1];
  assign length_q = len_q;

  // Replay starts with the full sync pattern sitting in the delay line
  assert_replay_starts_on_sync_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(emit_q) |-> (hist_q == PATTERN));

  // Replay never outlasts the header
  assert_replay_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    emit_q |-> (ecnt_q < ECW'(HDR_BITS)));

endmodule

// File: rtl/cfgfwd_frame_sink.sv
module cfgfwd_frame_sink
  import cfgfwd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  phase_t            phase,
  input  logic              din,
  output logic [DATA_W-1:0] frame_word,
  output logic              frame_valid,
  output logic              done,
  output logic              last_done
);

  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int FCW = $clog2(NUM_FRAMES + 1);

  fstate_t          fst_q;
  logic [BCW-1:0]   bit_cnt_q;
  logic [FCW-1:0]   frm_cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] word_q;
  logic             valid_q;
  logic             done_q;
  logic             word_end;

  assign word_end  = (phase == PH_FRAMES) && (fst_q == FS_DATA) &&
                     (bit_cnt_q == BCW'(DATA_W - 1));
  assign last_done = word_end && (frm_cnt_q == FCW'(NUM_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (clr) begin
      fst_q     <= FS_IDLE;
      bit_cnt_q <= '0;
      frm_cnt_q <= '0;
      shreg_q   <= '0;
      word_q    <= '0;
      valid_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (phase == PH_FRAMES) begin
        unique case (fst_q)
          FS_IDLE: if (!din) fst_q <= FS_GOT0;
          FS_GOT0: begin
            if (din) begin
              fst_q     <= FS_DATA;
              bit_cnt_q <= '0;
            end
          end
          default: begin
            shreg_q   <= {shreg_q[DATA_W-2:0], din};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (word_end) begin
              word_q    <= {shreg_q[DATA_W-2:0], din};
              valid_q   <= 1'b1;
              frm_cnt_q <= frm_cnt_q + 1'b1;
              fst_q     <= FS_IDLE;
              if (last_done) done_q <= 1'b1;
            end
          end
        endcase
      end else begin
        fst_q <= FS_IDLE;
      end
    end
  end

  assign frame_word  = word_q;
  assign frame_valid = valid_q;
  assign done        = done_q;

  assert_valid_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr) |=> done_q);

  assert_done_with_last_word_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> valid_q);

  assert_no_word_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr) |=> !valid_q);

endmodule

// File: rtl/cfgfwd_out_stage.sv
module cfgfwd_out_stage
  import cfgfwd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clr,
  input  logic   din,
  input  phase_t phase,
  input  logic   emit_on,
  input  logic   emit_bit,
  output logic   dout
);

  logic sel_bit;
  logic out_q;
  logic fall_q;

  // Replay beats bypass beats idle-high
  always_comb begin
    if (emit_on)                 sel_bit = emit_bit;
    else if (phase == PH_BYPASS) sel_bit = din;
    else                         sel_bit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) out_q <= 1'b1;
    else     out_q <= sel_bit;
  end

  // Launch on the falling edge for the next device's rising-edge sample
  always_ff @(negedge clk) begin
    fall_q <= out_q;
  end

  assign dout = fall_q;

  assert_bypass_follows_input_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BYPASS && !emit_on && !clr) |=> (out_q == $past(din)));

  assert_hold_high_R6: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_FRAMES || phase == PH_LEN) && !emit_on && !clr) |=> out_q);

  assert_restart_idles_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> out_q);

endmodule

// File: rtl/cfgfwd_chain_node.sv
module cfgfwd_chain_node
  import cfgfwd_pkg::*;
#(
  parameter int             DATA_W     = 32,
  parameter int             NUM_FRAMES = 4,
  parameter int             PRE_W      = 8,
  parameter logic [PRE_W-1:0] PATTERN  = 8'hF2,
  parameter int             LEN_W      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reconfig_req,
  input  logic              chain_cfg_en,
  input  logic              cfg_din,
  output logic              cfg_dout,
  output logic [DATA_W-1:0] frame_word,
  output logic              frame_valid,
  output logic [LEN_W-1:0]  length_count,
  output logic              load_done
);

  phase_t phase;
  logic   clr;
  logic   match;
  logic   last_done;
  logic   emit_on;
  logic   emit_bit;

  // Restart gate: reconfiguration re-arms only with the enable bit set
  assign clr = rst | (reconfig_req & chain_cfg_en);

  cfgfwd_seq #(.LEN_W(LEN_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .match     (match),
    .last_done (last_done),
    .phase     (phase)
  );

  cfgfwd_hdr_fwd #(.PRE_W(PRE_W), .PATTERN(PATTERN), .LEN_W(LEN_W)) hdr_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .din      (cfg_din),
    .phase    (phase),
    .match    (match),
    .emit_on  (emit_on),
    .emit_bit (emit_bit),
    .length_q (length_count)
  );

  cfgfwd_frame_sink #(.DATA_W(DATA_W), .NUM_FRAMES(NUM_FRAMES)) sink_i (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .phase       (phase),
    .din         (cfg_din),
    .frame_word  (frame_word),
    .frame_valid (frame_valid),
    .done        (load_done),
    .last_done   (last_done)
  );

  cfgfwd_out_stage out_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .din      (cfg_din),
    .phase    (phase),
    .emit_on  (emit_on),
    .emit_bit (emit_bit),
    .dout     (cfg_dout)
  );

  assert_reconfig_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (reconfig_req && !chain_cfg_en && load_done) |=> load_done);

  assert_reconfig_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (reconfig_req && chain_cfg_en) |=> !load_done);

endmodule

// File: tb/cfgfwd_chain_node_tb_top.sv
module cfgfwd_chain_node_tb_top;

  localparam int DW = 8;
  localparam int NF = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          reconfig_req;
  logic          chain_cfg_en;
  logic          cfg_din;
  logic          cfg_dout;
  logic [DW-1:0] frame_word;
  logic          frame_valid;
  logic [23:0]   length_count;
  logic          load_done;

  always #10 clk = ~clk;

  cfgfwd_chain_node #(.DATA_W(DW), .NUM_FRAMES(NF)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .reconfig_req (reconfig_req),
    .chain_cfg_en (chain_cfg_en),
    .cfg_din      (cfg_din),
    .cfg_dout     (cfg_dout),
    .frame_word   (frame_word),
    .frame_valid  (frame_valid),
    .length_count (length_count),
    .load_done    (load_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  bit          sb [0:511];
  int          slen;
  int          p_idx;
  int          last_own;
  int          n_own;
  int          own_end [0:7];
  logic [DW-1:0] own_word [0:7];
  logic [23:0] exp_len;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // One bit period: drive, rising edge, falling edge, settle
  task automatic step(input bit b);
    cfg_din = b;
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic add(input bit b);
    sb[slen] = b;
    slen++;
  endtask

  task automatic clear_stream();
    slen = 0; n_own = 0; last_own = -1; p_idx = -1;
  endtask

  task automatic add_hdr(input logic [23:0] len);
    for (int i = 7; i >= 0; i--) add(8'hF2 >> i);
    p_idx = slen - 1;
    for (int i = 23; i >= 0; i--) add(len[i]);
    exp_len = len;
  endtask

  task automatic add_frame(input logic [DW-1:0] w, input int gap,
                           input bit dbl0, input bit own);
    for (int i = 0; i < gap; i++) add(1'b1);
    add(1'b0);
    if (dbl0) add(1'b0);
    add(1'b1);
    for (int i = DW - 1; i >= 0; i--) add(w[i]);
    if (own) begin
      own_end[n_own]  = slen - 1;
      own_word[n_own] = w;
      n_own++;
      last_own = slen - 1;
    end
  endtask

  // Plays the stream and compares every output bit against the model
  task automatic run_stream(input string tag);
    int bad_pre = 0, bad_hdr = 0, bad_hold = 0, bad_byp = 0;
    int k = 0, bad_fv = 0;
    logic expb;
    for (int i = 0; i < slen; i++) begin
      if (i <= p_idx)            expb = 1'b1;
      else if (i <= p_idx + 32)  expb = sb[i - 8];
      else if (i <= last_own)    expb = 1'b1;
      else                       expb = sb[i];
      step(sb[i]);
      if (cfg_dout !== expb) begin
        if (i <= p_idx)           bad_pre++;
        else if (i <= p_idx + 32) bad_hdr++;
        else if (i <= last_own)   bad_hold++;
        else                      bad_byp++;
      end
      if (frame_valid === 1'b1) begin
        if (k >= n_own || i != own_end[k] || frame_word !== own_word[k]) bad_fv++;
        k++;
      end
      if (i < last_own && load_done !== 1'b0) bad_fv++;
    end
    chk(bad_pre == 0,  "R1", {tag, " idle before sync"}, bad_pre, 0);
    chk(bad_hdr == 0,  "R3", {tag, " header replay"}, bad_hdr, 0);
    chk(bad_hold == 0, "R6", {tag, " hold high"}, bad_hold, 0);
    chk(bad_byp == 0,  "R7", {tag, " bypass"}, bad_byp, 0);
    chk(bad_fv == 0,   "R5", {tag, " frame words"}, bad_fv, 0);
    chk(k == n_own,    "R8", {tag, " valid count"}, k, n_own);
    chk(load_done === 1'b1, "R7", {tag, " done"}, load_done, 1);
    chk(length_count === exp_len, "R4", {tag, " length"}, length_count, exp_len);
  endtask

  task automatic t_reset();
    rst = 1'b1; reconfig_req = 1'b0; chain_cfg_en = 1'b0;
    repeat (3) step(1'b1);
    chk(cfg_dout === 1'b1,    "R1", "reset dout", cfg_dout, 1);
    chk(load_done === 1'b0,   "R1", "reset done", load_done, 0);
    chk(frame_valid === 1'b0, "R1", "reset valid", frame_valid, 0);
    rst = 1'b0;
  endtask

  task automatic t_basic_load();
    clear_stream();
    add(1); add(1); add(1); add(1); add(0); add(1); add(1); add(0); add(1);
    add_hdr(24'h5A3C81);
    add_frame(8'hC6, 2, 0, 1);
    add_frame(8'h3B, 0, 0, 1);
    add_frame(8'h99, 1, 0, 0);
    add(0); add(1); add(1); add(0); add(0); add(1);
    run_stream("basic");
  endtask

  task automatic t_half_period();
    logic at_rise, at_fall;
    step(1'b0);
    cfg_din = 1'b1;
    @(posedge clk); #2 at_rise = cfg_dout;
    @(negedge clk); #2 at_fall = cfg_dout;
    chk(at_rise === 1'b0, "R2", "held until falling edge", at_rise, 0);
    chk(at_fall === 1'b1, "R2", "launched at falling edge", at_fall, 1);
  endtask

  task automatic t_reconfig_blocked();
    reconfig_req = 1'b1; chain_cfg_en = 1'b0;
    step(1'b0);
    reconfig_req = 1'b0;
    step(1'b1);
    chk(load_done === 1'b1, "R9", "blocked keeps done", load_done, 1);
    chk(cfg_dout === 1'b1,  "R9", "blocked keeps bypass (1)", cfg_dout, 1);
    step(1'b0);
    chk(cfg_dout === 1'b0,  "R9", "blocked keeps bypass (0)", cfg_dout, 0);
  endtask

  task automatic t_reconfig_load();
    reconfig_req = 1'b1; chain_cfg_en = 1'b1;
    step(1'b0);
    reconfig_req = 1'b0;
    chk(load_done === 1'b0, "R9", "enabled restart clears done", load_done, 0);
    chk(cfg_dout === 1'b1,  "R9", "enabled restart idles output", cfg_dout, 1);
    clear_stream();
    add(1); add(1);
    add_hdr(24'h000001);
    add_frame(8'h00, 3, 1, 1);   // R10: start pair opened by 0,0,1
    add_frame(8'hFF, 1, 1, 1);
    add_frame(8'hA5, 0, 0, 0);
    add(1); add(0); add(0);
    run_stream("reload R10");
  endtask

  initial begin
    cfg_din = 1'b1;
    t_reset();
    t_basic_load();
    t_half_period();
    t_reconfig_blocked();
    t_reconfig_load();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule